// File: doc/BRIEF.md
# Row-Column Mask Pixel Renderer

This block draws a coarse 40 by 40 cell colour picture without any frame store. Each of the three colour channels keeps two 40-bit masks, one across the columns and one down the rows, and a channel is lit in a cell only where both its column bit and its row bit are set. The picture is therefore the outer product of the row and column masks, held in 240 bits of registers. Each cell row is repeated over six consecutive scan lines, and each cell column lasts a fixed number of clocks.

A sync generator supplies three timing inputs. It pulses `line_start` at the beginning of every scan line. It holds `in_window` high for the 240 active lines. It pulses `render_go` where the visible part of a line begins. Software loads masks through a one-cycle write port and can rotate any column mask by one cell with wraparound, which scrolls that channel across the screen. Both take effect only while `in_window` is low, so no line is drawn from half-updated masks. The colour output is registered.

Top module: `rcmask_renderer`

## Requirements
- R1: For each cell the output bit of a channel is 1 only when both its column bit and its row bit are 1; `rgb` bit 0 is red, bit 1 green, bit 2 blue, and `wr_chan` codes 0, 1 and 2 select red, green and blue (code 3 selects nothing).
- R2: Masks are 40-bit vectors, most significant bit first: column c uses bit 39-c of the column mask and row r uses bit 39-r of the row mask.
- R3: When `render_go` is sampled high at clock edge T, column c is shown on `rgb` from edge T+1+12c up to edge T+1+12(c+1), for 12 clocks per cell by default.
- R4: After the 40th column `rgb` returns to 0 and stays 0 until the next `render_go`.
- R5: At every `line_start` with `in_window` low the row index returns to 0; active line k of the window (counting from 0) shows row k/6, so each row covers 6 lines.
- R6: `rgb` is 0 on the clock after any edge where `in_window` is low, and 0 on a line before its `render_go`.
- R7: A rotate of a channel's column mask gives new = {old[0], old[39:1]}: it shifts right by one and bit 0 wraps into bit 39.
- R8: Mask writes and rotates presented while `in_window` is high have no effect.
- R9: A column-mask write and a rotate aimed at the same channel in the same cycle store the written value; rotates of the other channels in that cycle still take place.
- R10: After reset `rgb` is 0 and all masks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle pulse at the start of each scan line |
| in_window | input | 1 | High during the 240 active lines |
| render_go | input | 1 | One-cycle pulse where the visible part of a line begins |
| wr_en | input | 1 | Mask write strobe |
| wr_row | input | 1 | 1 writes a row mask, 0 writes a column mask |
| wr_chan | input | 2 | Channel of the write: 0 red, 1 green, 2 blue |
| wr_data | input | 40 | Mask value, bit 39 is cell 0 |
| rot_en | input | 3 | Per-channel column-mask rotate (bit 0 red, 1 green, 2 blue) |
| rgb | output | 3 | Registered colour: bit 0 red, 1 green, 2 blue |

## Verification
The two functions that can fall in the same cycle are a column-mask write and a column rotate. The bench raises `wr_en` for red together with `rot_en` for all three channels in one blanking cycle. It judges the result on the next rendered line: the red columns must match the written value unrotated, while green and blue must appear shifted by one more cell. A second collision puts a write and a rotate inside the active window, and that line must render exactly as the line before it.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    localparam int NUM_CHAN = 3;

    typedef enum logic [1:0] {
        CH_RED = 2'd0,
        CH_GRN = 2'd1,
        CH_BLU = 2'd2
    } chan_e;

    // Registered colour word; packed order gives blue at bit 2, red at bit 0.
    typedef struct packed {
        logic blu;
        logic grn;
        logic red;
    } rgb_t;

    // Index counter width that tolerates a count of one.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rcm_mask_bank.sv
module rcm_mask_bank
    import rcm_pkg::*;
#(
    parameter int N_CELLS = 40
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_window,
    input  logic                              wr_en,
    input  logic                              wr_row,
    input  logic [1:0]                        wr_chan,
    input  logic [N_CELLS-1:0]                wr_data,
    input  logic [NUM_CHAN-1:0]               rot_en,
    output logic [NUM_CHAN-1:0][N_CELLS-1:0]  col_m,
    output logic [NUM_CHAN-1:0][N_CELLS-1:0]  row_m
);

    logic upd_ok;
    assign upd_ok = !in_window;

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        logic hit;
        assign hit = wr_en && (wr_chan == 2'(ch));

        // Column mask: write has priority over rotate (R9).
        always_ff @(posedge clk) begin
            if (rst) begin
                col_m[ch] <= '0;
            end else if (upd_ok) begin
                if (hit && !wr_row) begin
                    col_m[ch] <= wr_data;
                end else if (rot_en[ch]) begin
                    col_m[ch] <= {col_m[ch][0], col_m[ch][N_CELLS-1:1]};
                end
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                row_m[ch] <= '0;
            end else if (upd_ok && hit && wr_row) begin
                row_m[ch] <= wr_data;
            end
        end
    end

    // R8: masks frozen for the whole active window
    a_r8_frozen_in_window: assert property (@(posedge clk) disable iff (rst)
        in_window |=> ($stable(col_m) && $stable(row_m)));

endmodule

// File: rtl/rcm_row_seq.sv
module rcm_row_seq
    import rcm_pkg::*;
#(
    parameter int N_CELLS     = 40,
    parameter int LINE_REPEAT = 6
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              line_start,
    input  logic                              in_window,
    input  logic [NUM_CHAN-1:0][N_CELLS-1:0]  row_m,
    output logic [NUM_CHAN-1:0]               row_bits
);

    localparam int CW = cnt_width(N_CELLS);
    localparam int RW = $clog2(LINE_REPEAT + 1);
    localparam logic [CW-1:0] LAST_IDX   = CW'(N_CELLS - 1);
    localparam logic [RW-1:0] REP_FULL   = RW'(LINE_REPEAT);
    localparam logic [RW-1:0] REP_RELOAD = RW'(LINE_REPEAT - 1);

    logic [CW-1:0] row_idx;
    logic [RW-1:0] rep_cnt;

    function automatic logic [NUM_CHAN-1:0] pick(
        input logic [NUM_CHAN-1:0][N_CELLS-1:0] m,
        input logic [CW-1:0]                   r
    );
        logic [NUM_CHAN-1:0] b;
        logic [CW-1:0]       pos;
        pos = LAST_IDX - r;
        for (int ch = 0; ch < NUM_CHAN; ch++) begin
            b[ch] = m[ch][pos];
        end
        return b;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            row_idx  <= '0;
            rep_cnt  <= REP_FULL;
            row_bits <= '0;
        end else if (!in_window) begin
            // Blanking: park on row 0 and track its mask bits.
            row_idx  <= '0;
            rep_cnt  <= REP_FULL;
            row_bits <= pick(row_m, '0);
        end else if (line_start) begin
            if (rep_cnt == '0) begin
                rep_cnt <= REP_RELOAD;
                if (row_idx != LAST_IDX) begin
                    row_idx  <= row_idx + 1'b1;
                    row_bits <= pick(row_m, row_idx + 1'b1);
                end
            end else begin
                rep_cnt <= rep_cnt - 1'b1;
            end
        end
    end

    // R5: row index never leaves the grid
    a_r5_row_in_range: assert property (@(posedge clk) disable iff (rst)
        row_idx <= LAST_IDX);

    // R5: inside the window the row only holds or steps by one
    a_r5_row_step: assert property (@(posedge clk) disable iff (rst)
        in_window |=> (row_idx == $past(row_idx)) || (row_idx == $past(row_idx) + 1'b1));

endmodule

// File: rtl/rcm_col_seq.sv
module rcm_col_seq
    import rcm_pkg::*;
#(
    parameter int N_CELLS   = 40,
    parameter int CELL_CLKS = 12
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          render_go,
    output logic                          running,
    output logic [cnt_width(N_CELLS)-1:0] col_idx
);

    localparam int CW  = cnt_width(N_CELLS);
    localparam int KW  = cnt_width(CELL_CLKS);
    localparam logic [CW-1:0] LAST_COL = CW'(N_CELLS - 1);
    localparam logic [KW-1:0] LAST_CLK = KW'(CELL_CLKS - 1);

    logic [KW-1:0] clk_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            col_idx <= '0;
            clk_cnt <= '0;
        end else if (render_go) begin
            running <= 1'b1;
            col_idx <= '0;
            clk_cnt <= '0;
        end else if (running) begin
            if (clk_cnt == LAST_CLK) begin
                clk_cnt <= '0;
                if (col_idx == LAST_COL) begin
                    running <= 1'b0;
                end else begin
                    col_idx <= col_idx + 1'b1;
                end
            end else begin
                clk_cnt <= clk_cnt + 1'b1;
            end
        end
    end

    // R4: the line closes after the last clock of the last column
    a_r4_line_closes: assert property (@(posedge clk) disable iff (rst)
        (running && col_idx == LAST_COL && clk_cnt == LAST_CLK && !render_go) |=> !running);

    // R3: column index stays inside the grid
    a_r3_col_in_range: assert property (@(posedge clk) disable iff (rst)
        col_idx <= LAST_COL);

endmodule

// File: rtl/rcmask_renderer.sv
module rcmask_renderer
    import rcm_pkg::*;
#(
    parameter int N_CELLS     = 40,
    parameter int LINE_REPEAT = 6,
    parameter int CELL_CLKS   = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_start,
    input  logic               in_window,
    input  logic               render_go,
    input  logic               wr_en,
    input  logic               wr_row,
    input  logic [1:0]         wr_chan,
    input  logic [N_CELLS-1:0] wr_data,
    input  logic [2:0]         rot_en,
    output logic [2:0]         rgb
);

    localparam int CW = cnt_width(N_CELLS);
    localparam logic [CW-1:0] LAST_IDX = CW'(N_CELLS - 1);

    logic [NUM_CHAN-1:0][N_CELLS-1:0] col_m;
    logic [NUM_CHAN-1:0][N_CELLS-1:0] row_m;
    logic [NUM_CHAN-1:0]              row_bits;
    logic                             running;
    logic [CW-1:0]                    col_idx;
    logic [CW-1:0]                    col_pos;
    logic [NUM_CHAN-1:0]              col_bits;
    rgb_t                             pix_d;
    rgb_t                             pix_q;

    rcm_mask_bank #(.N_CELLS(N_CELLS)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .in_window (in_window),
        .wr_en     (wr_en),
        .wr_row    (wr_row),
        .wr_chan   (wr_chan),
        .wr_data   (wr_data),
        .rot_en    (rot_en),
        .col_m     (col_m),
        .row_m     (row_m)
    );

    rcm_row_seq #(.N_CELLS(N_CELLS), .LINE_REPEAT(LINE_REPEAT)) u_rows (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .in_window  (in_window),
        .row_m      (row_m),
        .row_bits   (row_bits)
    );

    rcm_col_seq #(.N_CELLS(N_CELLS), .CELL_CLKS(CELL_CLKS)) u_cols (
        .clk       (clk),
        .rst       (rst),
        .render_go (render_go),
        .running   (running),
        .col_idx   (col_idx)
    );

    assign col_pos = LAST_IDX - col_idx;

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_colbit
        assign col_bits[ch] = col_m[ch][col_pos];
    end

    always_comb begin
        pix_d = '0;
        if (in_window && running) begin
            pix_d = rgb_t'(col_bits & row_bits);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q <= '0;
        end else begin
            pix_q <= pix_d;
        end
    end

    assign rgb = pix_q;

    // R6: dark on the clock after any blanking edge
    a_r6_dark_in_blank: assert property (@(posedge clk) disable iff (rst)
        !in_window |=> (rgb == 3'b000));

    // R4: dark on the clock after the column engine is idle
    a_r4_dark_when_idle: assert property (@(posedge clk) disable iff (rst)
        !running |=> (rgb == 3'b000));

endmodule

// File: tb/sim_rcmask_renderer.sv
module sim_rcmask_renderer;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 40;
    localparam int K  = 12;
    localparam int RP = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         line_start = 1'b0;
    logic         in_window = 1'b0;
    logic         render_go = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_row = 1'b0;
    logic [1:0]   wr_chan = 2'd0;
    logic [N-1:0] wr_data = '0;
    logic [2:0]   rot_en = 3'b000;
    logic [2:0]   rgb;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    // Bench model of the masks
    logic [N-1:0] m_col [3];
    logic [N-1:0] m_row [3];
    int           cur_row = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rcmask_renderer u0 (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .in_window  (in_window),
        .render_go  (render_go),
        .wr_en      (wr_en),
        .wr_row     (wr_row),
        .wr_chan    (wr_chan),
        .wr_data    (wr_data),
        .rot_en     (rot_en),
        .rgb        (rgb)
    );

    // Monitor: pops one expected item per cycle while the queue holds any.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rgb !== e) begin
                failures++;
                $display("FAIL %s rgb actual=%b expected=%b at %0t", t, rgb, e, $time);
            end
        end
    end

    function automatic logic [2:0] exp_pix(input int c, input int r);
        logic [2:0] p;
        for (int ch = 0; ch < 3; ch++) begin
            p[ch] = m_col[ch][N-1-c] & m_row[ch][N-1-r];
        end
        return p;
    endfunction

    task automatic chk(input bit ok, input string t, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", t, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic start_line(input bit win);
        line_start = 1'b1;
        in_window  = win;
        tick();
        line_start = 1'b0;
        tick();
    endtask

    // Driver: push the whole expected line, then fire render_go.
    task automatic render_line(input string t);
        exp_q.push_back(3'b000); tag_q.push_back({t, " R6 before render_go"});
        exp_q.push_back(3'b000); tag_q.push_back({t, " R6 before render_go"});
        for (int c = 0; c < N; c++) begin
            for (int k = 0; k < K; k++) begin
                exp_q.push_back(in_window ? exp_pix(c, cur_row) : 3'b000);
                tag_q.push_back(in_window ? {t, " R1 R2 R3 cell"} : {t, " R6 blanking"});
            end
        end
        for (int z = 0; z < 3; z++) begin
            exp_q.push_back(3'b000); tag_q.push_back({t, " R4 after last column"});
        end
        render_go = 1'b1;
        tick();
        render_go = 1'b0;
        while (exp_q.size() > 0) tick();
    endtask

    task automatic mwrite(input bit is_row, input int ch, input logic [N-1:0] d);
        wr_en = 1'b1; wr_row = is_row; wr_chan = 2'(ch); wr_data = d;
        if (!in_window && ch < 3) begin
            if (is_row) m_row[ch] = d; else m_col[ch] = d;
        end
        tick();
        wr_en = 1'b0;
    endtask

    function automatic logic [N-1:0] rot1(input logic [N-1:0] v);
        return {v[0], v[N-1:1]};
    endfunction

    initial begin
        for (int ch = 0; ch < 3; ch++) begin
            m_col[ch] = '0;
            m_row[ch] = '0;
        end
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk(rgb == 3'b000, "R10 reset output", rgb, 3'b000);

        // R10: masks are zero after reset, so an active line is dark
        start_line(1'b1);
        cur_row = 0;
        render_line("R10 zero masks");
        start_line(1'b0);

        // Load masks during blanking
        mwrite(1'b0, 0, 40'hF0F00F0FA5);
        mwrite(1'b0, 1, 40'h8000000001);
        mwrite(1'b0, 2, 40'h123456789A);
        mwrite(1'b1, 0, 40'hFFFFFFFFFF);
        mwrite(1'b1, 1, 40'hAAAAAAAAAA);
        mwrite(1'b1, 2, 40'h8100000001);
        mwrite(1'b1, 3, 40'hFFFFFFFFFF);   // R1: code 3 selects no channel

        // R6: render_go on a blanking line stays dark
        render_line("R6 blank line");

        // Frame 1
        for (int k = 0; k < 240; k++) begin
            start_line(1'b1);
            cur_row = k / RP;
            if (k == 7) begin
                // R8: write and rotate inside the window are ignored
                wr_en = 1'b1; wr_row = 1'b0; wr_chan = 2'd0; wr_data = '0;
                rot_en = 3'b111;
                tick();
                wr_en = 1'b0; rot_en = 3'b000;
                mwrite(1'b1, 1, 40'h0000000000);
            end
            if (k == 0)   render_line("R5 line 0 row 0");
            if (k == 5)   render_line("R5 line 5 row 0");
            if (k == 6)   render_line("R5 line 6 row 1");
            if (k == 8)   render_line("R8 line 8 after ignored updates");
            if (k == 13)  render_line("R5 line 13 row 2");
            if (k == 239) render_line("R5 line 239 row 39");
        end

        // Blanking: rotate green and blue (R7)
        start_line(1'b0);
        rot_en = 3'b110;
        m_col[1] = rot1(m_col[1]);
        m_col[2] = rot1(m_col[2]);
        tick();
        rot_en = 3'b000;
        chk(m_col[1] == 40'hC000000000, "R7 wrap model", rgb, rgb);

        // R9: write red column and rotate all in the same cycle
        wr_en = 1'b1; wr_row = 1'b0; wr_chan = 2'd0; wr_data = 40'h000000FFFF;
        rot_en = 3'b111;
        m_col[0] = 40'h000000FFFF;
        m_col[1] = rot1(m_col[1]);
        m_col[2] = rot1(m_col[2]);
        tick();
        wr_en = 1'b0; rot_en = 3'b000;
        start_line(1'b0);

        // Frame 2: row index back at 0 (R5), new column masks (R7, R9)
        for (int k = 0; k < 7; k++) begin
            start_line(1'b1);
            cur_row = k / RP;
            if (k == 0) render_line("R7 R9 frame 2 line 0");
            if (k == 6) render_line("R7 R9 frame 2 line 6");
        end
        start_line(1'b0);
        tick();
        chk(rgb == 3'b000, "R6 blank after frame", rgb, 3'b000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all requirements actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule